// File: doc/BRIEF.md
# Self-Correcting Triple-Voted Register Bank

This block is a bank of 8-bit configuration registers built to survive single-event upsets. Each bit is stored in three copies, and every consumer sees the bitwise majority of the three. On every clock that does not carry a host write to a register, all three copies of that register are reloaded from the voted value. A single flipped copy is therefore repaired one clock after it appears, with no action from the host.

The host reaches the bank through a plain address/data port that takes the place of a serial management bus. A write loads all three copies of the addressed register at once. A read returns the voted value one clock later. The bank reports which copy disagreed with the vote on the current cycle, and it keeps a sticky error flag that the host clears by writing to the status address. The same voting cell that stores the configuration bits also stores the sticky flag, which is a piece of control state, so one cell serves both configuration and state registers.

A fault-injection input flips one bit of one copy of one register. It stands in for a radiation strike so that the repair path can be exercised through ports.

Top module: `tmrVoteBank`

## Requirements
- R1: After synchronous reset, register i (0 to 92) reads as the low 8 bits of (i XOR 8'h5A). Immediately after reset, `errSticky` is 0 and `copyErr` is 3'b000.
- R2: A host write (`hostEn`=1, `hostWr`=1) to address i below 93 loads `hostWdata` into all three copies at that clock edge. A host read (`hostEn`=1, `hostWr`=0) raises `rdValid` for exactly the following cycle and presents the voted value on `rdData` in that cycle.
- R3: While one copy of a register is corrupted, a read of that register still returns the value last written to it.
- R4: In the cycle after an injection edge, `copyErr` has exactly bit k set, where k is the corrupted copy (`injCopy` value 0, 1 or 2). At most one bit of `copyErr` is ever set. An `injCopy` value of 3 flips nothing.
- R5: With no new injection, a corrupted copy is repaired at the next clock edge, so `copyErr` returns to 3'b000. A later upset of a different copy at the same bit therefore does not change the voted value.
- R6: `errSticky` becomes 1 at the clock edge that follows any cycle with a nonzero `copyErr`, and it stays 1 until it is cleared.
- R7: A host write to the status address 93 clears `errSticky`. If `copyErr` is nonzero at that same edge, setting takes priority and the flag stays 1.
- R8: A read of any address from 93 to 127 returns 8'h00 with `rdValid`=1, and `addrErr` is 1 for that one response cycle only. In-range reads leave `addrErr` at 0.
- R9: Host writes to address 93 or higher leave every register unchanged.
- R10: When a host write and an injection hit the same register at the same edge, the write wins: all three copies take the written data and `copyErr` stays 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostEn | input | 1 | Host access request for this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 7 | Register address; 93 is the status address |
| hostWdata | input | 8 | Write data |
| injEn | input | 1 | Flip one stored bit at this edge |
| injAddr | input | 7 | Register hit by the upset |
| injCopy | input | 2 | Copy hit (0, 1, 2; 3 = none) |
| injBit | input | 3 | Bit position flipped |
| rdValid | output | 1 | Read response valid |
| rdData | output | 8 | Voted read data |
| addrErr | output | 1 | Out-of-range read response |
| errSticky | output | 1 | Sticky copy-disagreement flag |
| copyErr | output | 3 | Copy currently disagreeing with the vote, one bit per copy |

## Verification
Each result has a fixed cycle. A read response, including `addrErr`, appears in the cycle after the request edge. `copyErr` reflects an upset in the cycle after the injection edge and clears one edge later. `errSticky` sets on that same repair edge and clears on the edge of the status write. The bench drives inputs just after a falling edge and samples just before the next falling edge, so each sample sees exactly one rising edge. It sweeps every register, every copy, every out-of-range address and the clear/set collision. The expected values are computed arithmetically from the reset and write formulas.

// File: rtl/tmrBankPkg.sv
package tmrBankPkg;

  // Strobes from the control decoder to the datapath, one per host action
  typedef struct packed {
    logic wrEn;    // in-range register write
    logic rdEn;    // any read
    logic rdBad;   // read of an address with no register behind it
    logic clrErr;  // write to the status address
  } ctrlStrobes_t;

endpackage

// File: rtl/tmrCell.sv
// Triple-stored register with majority read and per-cycle write-back.
// Used for configuration bits and for control state alike.
module tmrCell #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic [2:0]   flipEn,
  input  logic [W-1:0] flipMask,
  output logic [W-1:0] voted,
  output logic [2:0]   copyErr
);
  localparam int COPIES = 3;

  logic [W-1:0] copies [COPIES];

  assign voted = (copies[0] & copies[1]) | (copies[0] & copies[2]) | (copies[1] & copies[2]);

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst) begin
        copies[k] <= RST_VAL;
      end else if (load) begin
        copies[k] <= din;
      end else begin
        copies[k] <= voted ^ (flipEn[k] ? flipMask : '0);
      end
    end
    assign copyErr[k] = (copies[k] != voted);
  end

endmodule

// File: rtl/tmrBankCtrl.sv
// Decodes host requests into strobes and keeps the sticky error flag
// in a voted state cell.
module tmrBankCtrl
  import tmrBankPkg::*;
#(
  parameter int NUM_REGS = 93,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostEn,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [2:0]        bankCopyErr,
  output ctrlStrobes_t      strobes,
  output logic              errSticky,
  output logic [2:0]        stateCopyErr
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS);

  logic inRange;
  logic stickyNext;
  logic anyErr;

  assign inRange = (hostAddr < STATUS_ADDR);

  always_comb begin
    strobes        = '0;
    strobes.wrEn   = hostEn && hostWr && inRange;
    strobes.rdEn   = hostEn && !hostWr;
    strobes.rdBad  = hostEn && !hostWr && !inRange;
    strobes.clrErr = hostEn && hostWr && (hostAddr == STATUS_ADDR);
  end

  // Set has priority over clear
  assign anyErr     = (|bankCopyErr) || (|stateCopyErr);
  assign stickyNext = anyErr || (errSticky && !strobes.clrErr);

  tmrCell #(
    .W      (1),
    .RST_VAL(1'b0)
  ) u_stickyCell (
    .clk     (clk),
    .rst     (rst),
    .load    (1'b1),
    .din     (stickyNext),
    .flipEn  (3'b000),
    .flipMask(1'b0),
    .voted   (errSticky),
    .copyErr (stateCopyErr)
  );

endmodule

// File: rtl/tmrBankDp.sv
// Register storage, fault injection, read mux and copy-error reduction.
module tmrBankDp
  import tmrBankPkg::*;
#(
  parameter int NUM_REGS = 93,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEF_SEED = 8'h5A,
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [1:0]        injCopy,
  input  logic [BIT_W-1:0]  injBit,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              addrErr,
  output logic [2:0]        bankCopyErr
);
  logic [DATA_W-1:0] regVal   [NUM_REGS];
  logic [2:0]        regErr   [NUM_REGS];
  logic [2:0]        injSel;
  logic [DATA_W-1:0] injMask;
  logic [DATA_W-1:0] rdSel;

  assign injSel  = 3'b001 << injCopy;
  assign injMask = DATA_W'(1) << injBit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = injEn && (injAddr == ADDR_W'(i));
    tmrCell #(
      .W      (DATA_W),
      .RST_VAL(DATA_W'(i) ^ DEF_SEED)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .load    (strobes.wrEn && (hostAddr == ADDR_W'(i))),
      .din     (hostWdata),
      .flipEn  (hit ? injSel : 3'b000),
      .flipMask(injMask),
      .voted   (regVal[i]),
      .copyErr (regErr[i])
    );
  end

  always_comb begin
    bankCopyErr = '0;
    rdSel       = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      bankCopyErr = bankCopyErr | regErr[i];
      if (hostAddr == ADDR_W'(i)) rdSel = regVal[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      addrErr <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdEn;
      addrErr <= strobes.rdBad;
      if (strobes.rdEn) rdData <= strobes.rdBad ? '0 : rdSel;
    end
  end

endmodule

// File: rtl/tmrVoteBank.sv
module tmrVoteBank
  import tmrBankPkg::*;
#(
  parameter int NUM_REGS = 93,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter logic [DATA_W-1:0] DEF_SEED = 8'h5A,
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostEn,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [1:0]        injCopy,
  input  logic [BIT_W-1:0]  injBit,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              addrErr,
  output logic              errSticky,
  output logic [2:0]        copyErr
);
  ctrlStrobes_t strobes;
  logic [2:0]   bankCopyErr;
  logic [2:0]   stateCopyErr;

  tmrBankCtrl #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .hostEn      (hostEn),
    .hostWr      (hostWr),
    .hostAddr    (hostAddr),
    .bankCopyErr (bankCopyErr),
    .strobes     (strobes),
    .errSticky   (errSticky),
    .stateCopyErr(stateCopyErr)
  );

  tmrBankDp #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DEF_SEED(DEF_SEED)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .injEn      (injEn),
    .injAddr    (injAddr),
    .injCopy    (injCopy),
    .injBit     (injBit),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .addrErr    (addrErr),
    .bankCopyErr(bankCopyErr)
  );

  assign copyErr = bankCopyErr | stateCopyErr;

endmodule

// File: rtl/tmrVoteBankChk.sv
module tmrVoteBankChk #(
  parameter int NUM_REGS = 93,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              hostEn,
  input logic              hostWr,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              injEn,
  input logic [ADDR_W-1:0] injAddr,
  input logic [1:0]        injCopy,
  input logic [BIT_W-1:0]  injBit,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              addrErr,
  input logic              errSticky,
  input logic [2:0]        copyErr
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_REGS);

  a_r2_rd_valid: assert property (@(posedge clk) disable iff (rst)
    (hostEn && !hostWr) |=> rdValid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(hostEn && !hostWr) |=> !rdValid);
  a_r4_single_copy: assert property (@(posedge clk) disable iff (rst)
    $onehot0(copyErr));
  a_r5_scrub: assert property (@(posedge clk) disable iff (rst)
    ((copyErr != 3'b000) && !injEn) |=> (copyErr == 3'b000));
  a_r6_sticky_set: assert property (@(posedge clk) disable iff (rst)
    (copyErr != 3'b000) |=> errSticky);
  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (errSticky && !(hostEn && hostWr && hostAddr == STATUS_ADDR)) |=> errSticky);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (hostEn && hostWr && hostAddr == STATUS_ADDR && copyErr == 3'b000) |=> !errSticky);
  a_r8_bad_read: assert property (@(posedge clk) disable iff (rst)
    (hostEn && !hostWr && hostAddr >= STATUS_ADDR) |=> (addrErr && rdData == '0));
  a_r8_good_read: assert property (@(posedge clk) disable iff (rst)
    !(hostEn && !hostWr && hostAddr >= STATUS_ADDR) |=> !addrErr);

endmodule

bind tmrVoteBank tmrVoteBankChk #(
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tmrVoteBank_tb.sv
`timescale 1ns/1ps
module tmrVoteBank_tb;
  localparam int NREG = 93;

  logic       clk = 1'b0;
  logic       rst;
  logic       hostEn, hostWr;
  logic [6:0] hostAddr;
  logic [7:0] hostWdata;
  logic       injEn;
  logic [6:0] injAddr;
  logic [1:0] injCopy;
  logic [2:0] injBit;
  logic       rdValid, addrErr, errSticky;
  logic [7:0] rdData;
  logic [2:0] copyErr;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tmrVoteBank u_dut (
    .clk(clk), .rst(rst), .hostEn(hostEn), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .injEn(injEn), .injAddr(injAddr), .injCopy(injCopy),
    .injBit(injBit), .rdValid(rdValid), .rdData(rdData), .addrErr(addrErr),
    .errSticky(errSticky), .copyErr(copyErr)
  );

  function automatic logic [7:0] resetVal(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] patVal(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    hostEn = 0; hostWr = 0; injEn = 0;
  endtask

  // Drive after a falling edge, one rising edge, sample at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic hostWrite(int a, int d);
    hostEn = 1; hostWr = 1; hostAddr = 7'(a); hostWdata = 8'(d);
    step();
    idle();
  endtask

  task automatic hostRead(int a, output logic [7:0] d, output logic v, output logic e);
    hostEn = 1; hostWr = 0; hostAddr = 7'(a);
    step();
    d = rdData; v = rdValid; e = addrErr;
    idle();
  endtask

  initial begin
    logic [7:0] d;
    logic v, e;
    rst = 1; idle(); hostAddr = 0; hostWdata = 0; injAddr = 0; injCopy = 0; injBit = 0;
    repeat (3) step();
    rst = 0;
    step();

    // R1: reset state
    check("R1 sticky", errSticky, 0);
    check("R1 copyErr", copyErr, 0);
    for (int i = 0; i < NREG; i++) begin
      hostRead(i, d, v, e);
      check("R1 reset value", d, resetVal(i));
      check("R2 rdValid", v, 1);
      check("R8 in-range addrErr", e, 0);
    end
    step();
    check("R2 rdValid drops", rdValid, 0);

    // R2: write then read every register
    for (int i = 0; i < NREG; i++) hostWrite(i, patVal(i));
    for (int i = 0; i < NREG; i++) begin
      hostRead(i, d, v, e);
      check("R2 readback", d, patVal(i));
    end

    // R3..R7: upset every copy of every register
    for (int i = 0; i < NREG; i++) begin
      for (int k = 0; k < 3; k++) begin
        injEn = 1; injAddr = 7'(i); injCopy = 2'(k); injBit = 3'(i % 8);
        step();
        idle();
        check("R4 copyErr onehot", copyErr, 1 << k);
        hostRead(i, d, v, e);
        check("R3 voted read", d, patVal(i));
        check("R5 repaired", copyErr, 0);
        check("R6 sticky set", errSticky, 1);
        hostWrite(NREG, 8'hFF);
        check("R7 sticky cleared", errSticky, 0);
      end
    end

    // R5: two successive upsets of the same bit in different copies
    injEn = 1; injAddr = 7'd10; injCopy = 2'd0; injBit = 3'd3;
    step();
    injCopy = 2'd1;
    step();
    idle();
    hostRead(10, d, v, e);
    check("R5 serial upsets corrected", d, patVal(10));
    hostWrite(NREG, 0);

    // R4: copy selector 3 flips nothing
    injEn = 1; injAddr = 7'd4; injCopy = 2'd3; injBit = 3'd0;
    step();
    idle();
    check("R4 copy3 no effect", copyErr, 0);
    step();
    check("R4 copy3 sticky", errSticky, 0);

    // R6: sticky holds across idle cycles
    injEn = 1; injAddr = 7'd2; injCopy = 2'd2; injBit = 3'd7;
    step();
    idle();
    repeat (4) step();
    check("R6 sticky held", errSticky, 1);

    // R7: clear and set at the same edge -> set wins
    hostWrite(NREG, 0);
    check("R7 cleared before collision", errSticky, 0);
    injEn = 1; injAddr = 7'd20; injCopy = 2'd1; injBit = 3'd1;
    step();
    idle();
    hostWrite(NREG, 0);
    check("R7 set wins over clear", errSticky, 1);
    hostWrite(NREG, 0);
    check("R7 clear after collision", errSticky, 0);

    // R10: write and upset on the same register in the same cycle
    injEn = 1; injAddr = 7'd5; injCopy = 2'd1; injBit = 3'd2;
    hostEn = 1; hostWr = 1; hostAddr = 7'd5; hostWdata = 8'hC3;
    step();
    idle();
    check("R10 no copy error", copyErr, 0);
    step();
    check("R10 sticky untouched", errSticky, 0);
    hostRead(5, d, v, e);
    check("R10 write wins", d, 8'hC3);

    // R8: out-of-range reads
    for (int a = NREG; a < 128; a++) begin
      hostRead(a, d, v, e);
      check("R8 bad data", d, 0);
      check("R8 bad valid", v, 1);
      check("R8 addrErr", e, 1);
    end
    step();
    check("R8 addrErr one cycle", addrErr, 0);

    // R9: writes at or above the status address touch no register
    hostWrite(NREG, 8'hFF);
    hostWrite(100, 8'hFF);
    hostWrite(127, 8'h00);
    for (int i = 0; i < NREG; i++) begin
      hostRead(i, d, v, e);
      check("R9 unchanged", d, (i == 5) ? 8'hC3 : patVal(i));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule